// File: doc/BRIEF.md
# Lane Gearbox: Serial/Parallel Converter with Variable Ratio

This block converts one lane in both directions. The deserializer packs a serial bit stream into parallel words, and the serializer unpacks parallel words into a serial stream. Both halves run on a single bit clock. An internal word counter marks the word boundary, and that boundary is brought out as `wordTick`. The word width is set by the `cfgWidth` input to any value from 2 to 8. The serial side can carry one bit per clock or two bits per clock (double rate).

Two instances can be chained to build 10-bit or 14-bit words. One instance is the master and owns the low half of the word. The other is the slave and owns the high half. Bits pass between them through dedicated cascade pins. A `bitslip` pulse delays the word boundary by one clock. Repeated pulses let a receiver walk the boundary onto a known training pattern. Configuration inputs are meant to be set while reset is asserted.

Top module: `lane_gearbox`

## Requirements
- R1: While `rstN` is low (asynchronous, active low), `parOut` and `serOut` read zero and the word counter returns to its start.
- R2: With `cfgRole`=0 (standalone) and `cfgDdr`=0, `serIn[0]` is sampled on every rising clock edge. On each edge where `wordTick` is high, the last W sampled bits (W = `cfgWidth`, binary) are captured into `parOut`, with the earliest bit in bit 0. `parOut` is unchanged on every other edge.
- R3: With `cfgDdr`=0, `wordTick` is high for exactly one cycle in every W cycles, for any W from 2 to 8.
- R4: With `cfgDdr`=1, two bits are taken per clock, and `serIn[0]` is the earlier of the two. W may be 2, 4, 6 or 8, and `wordTick` is high for one cycle in every W/2.
- R5: With `cfgDdr`=0, `parIn[W-1:0]` is loaded on the edge where `wordTick` is high. Bit k of that word then appears on `serOut[0]` during the k-th cycle after the load (k counted from 0), so the word goes out LSB first. `serOut[1]` stays 0.
- R6: With `cfgDdr`=1, the k-th cycle after a load presents word bit 2k on `serOut[0]` and word bit 2k+1 on `serOut[1]`.
- R7: A cycle with `bitslip` high has `wordTick` low and holds the counter, so every later boundary moves one clock later. `parOut` does not change on the following edge.
- R8: For cascading, set `cfgRole`=1 on the master and 2 on the slave, with `cfgWidth` of 10 or 14 on both, in single-rate mode. Wire slave `deserCascOut` to master `deserCascIn`, and feed the stream to slave `serIn[0]`. The master's `parOut[W/2-1:0]` then holds the earliest W/2 bits and the slave's holds the later W/2. The master's own `serIn` is ignored.
- R9: In the same cascade, wire slave `serCascOut` to master `serCascIn`, and put the low half of the word on the master's `parIn` and the high half on the slave's. The master's `serOut[0]` then emits all W bits, LSB first, one per cycle.
- R10: The bits of `parOut` at and above the instance's share of the word (W standalone, W/2 in a cascade) read zero after a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWidth | input | 4 | Total word width in bits (2..8, or 10/14 in a cascade) |
| cfgDdr | input | 1 | 1 = two serial bits per clock |
| cfgRole | input | 2 | 0 standalone, 1 cascade master, 2 cascade slave |
| bitslip | input | 1 | Delay the word boundary by one clock |
| serIn | input | 2 | Serial input; bit 0 only in single-rate mode |
| deserCascIn | input | 1 | Deserializer chain input from the slave (master only) |
| deserCascOut | output | 1 | Deserializer chain output toward the master |
| parOut | output | 8 | Captured parallel word (this instance's share) |
| parIn | input | 8 | Parallel word to transmit (this instance's share) |
| serOut | output | 2 | Serial output; bit 1 is 0 in single-rate mode |
| serCascIn | input | 1 | Serializer chain input from the slave (master only) |
| serCascOut | output | 1 | Serializer chain output toward the master |
| wordTick | output | 1 | High in the cycle whose clock edge ends a word |

## Verification
`wordTick` is combinational, so the bench compares it in the same cycle against its own count of cycles since the last boundary, and that count also tracks bitslip holds. A captured word is due on `parOut` one cycle after the cycle in which the tick was seen. Serial group k of a word loaded at a tick is due k+1 cycles after that tick. Each expected item carries its due cycle, and the monitor compares an item only in that cycle, sampling at the falling edge, after the registers have settled.

// File: rtl/gearbox_pkg.sv
package gearbox_pkg;
  localparam int SEG_MAX = 8;
  localparam int CFG_W   = 4;
  localparam int SEG_W   = $clog2(SEG_MAX + 1);

  typedef enum logic [1:0] {
    ROLE_SOLO   = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  typedef struct packed {
    logic             wordEdge;
    logic             ddr;
    role_e            role;
    logic [SEG_W-1:0] segW;
  } gearCtl_t;
endpackage

// File: rtl/gear_ctrl.sv
module gear_ctrl
  import gearbox_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWidth,
  input  logic             cfgDdr,
  input  logic [1:0]       cfgRole,
  input  logic             bitslip,
  output gearCtl_t         ctl
);
  logic [SEG_W-1:0] segW;
  logic [CFG_W-1:0] perWord;
  logic [CFG_W-1:0] lastCnt;
  logic [CFG_W-1:0] cnt;
  role_e            role;
  logic             edgeNow;

  always_comb begin
    role    = role_e'(cfgRole);
    segW    = (role == ROLE_SOLO) ? SEG_W'(cfgWidth) : SEG_W'(cfgWidth >> 1);
    perWord = cfgDdr ? (cfgWidth >> 1) : cfgWidth;
    lastCnt = (perWord == '0) ? '0 : perWord - 1'b1;
    edgeNow = (cnt >= lastCnt) && !bitslip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!bitslip) begin
      cnt <= edgeNow ? '0 : cnt + 1'b1;
    end
  end

  assign ctl = '{wordEdge: edgeNow, ddr: cfgDdr, role: role, segW: segW};
endmodule

// File: rtl/deser_path.sv
module deser_path
  import gearbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  gearCtl_t           ctl,
  input  logic [1:0]         serIn,
  input  logic               cascIn,
  output logic [SEG_MAX-1:0] parOut,
  output logic               cascOut
);
  localparam logic [SEG_W-1:0] SEG_TOP = SEG_W'(SEG_MAX);

  logic [SEG_MAX-1:0] sr;
  logic [SEG_MAX-1:0] srNext;
  logic [SEG_MAX-1:0] srTap;
  logic [SEG_W-1:0]   dropBits;
  logic               headBit;

  always_comb begin
    dropBits = SEG_TOP - ctl.segW;
    headBit  = (ctl.role == ROLE_MASTER) ? cascIn : serIn[0];
    if (ctl.ddr) begin
      srNext = {serIn[1], serIn[0], sr[SEG_MAX-1:2]};
    end else begin
      srNext = {headBit, sr[SEG_MAX-1:1]};
    end
    srTap = sr >> dropBits;
  end

  assign cascOut = srTap[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr     <= '0;
      parOut <= '0;
    end else begin
      sr <= srNext;
      if (ctl.wordEdge) begin
        parOut <= srNext >> dropBits;
      end
    end
  end
endmodule

// File: rtl/ser_path.sv
module ser_path
  import gearbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  gearCtl_t           ctl,
  input  logic [SEG_MAX-1:0] parIn,
  input  logic               cascIn,
  output logic [1:0]         serOut,
  output logic               cascOut
);
  logic [SEG_MAX-1:0] sr;
  logic [SEG_MAX-1:0] srNext;
  logic [SEG_MAX-1:0] keepMask;

  always_comb begin
    for (int i = 0; i < SEG_MAX; i++) begin
      keepMask[i] = (i < int'(ctl.segW));
    end
    srNext = ctl.ddr ? (sr >> 2) : (sr >> 1);
    if (ctl.role == ROLE_MASTER && !ctl.ddr) begin
      for (int i = 0; i < SEG_MAX; i++) begin
        if (i == int'(ctl.segW) - 1) srNext[i] = cascIn;
      end
    end
    if (ctl.wordEdge) begin
      srNext = parIn & keepMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr <= '0;
    end else begin
      sr <= srNext;
    end
  end

  assign serOut  = ctl.ddr ? sr[1:0] : {1'b0, sr[0]};
  assign cascOut = sr[0];
endmodule

// File: rtl/lane_gearbox.sv
module lane_gearbox
  import gearbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   cfgWidth,
  input  logic               cfgDdr,
  input  logic [1:0]         cfgRole,
  input  logic               bitslip,
  input  logic [1:0]         serIn,
  input  logic               deserCascIn,
  output logic               deserCascOut,
  output logic [SEG_MAX-1:0] parOut,
  input  logic [SEG_MAX-1:0] parIn,
  output logic [1:0]         serOut,
  input  logic               serCascIn,
  output logic               serCascOut,
  output logic               wordTick
);
  gearCtl_t ctl;

  gear_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWidth (cfgWidth),
    .cfgDdr   (cfgDdr),
    .cfgRole  (cfgRole),
    .bitslip  (bitslip),
    .ctl      (ctl)
  );

  deser_path uDeser (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .serIn   (serIn),
    .cascIn  (deserCascIn),
    .parOut  (parOut),
    .cascOut (deserCascOut)
  );

  ser_path uSer (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .parIn   (parIn),
    .cascIn  (serCascIn),
    .serOut  (serOut),
    .cascOut (serCascOut)
  );

  assign wordTick = ctl.wordEdge;
endmodule

// File: rtl/gearbox_checker.sv
module gearbox_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] cfgWidth,
  input logic       cfgDdr,
  input logic [1:0] cfgRole,
  input logic       bitslip,
  input logic [7:0] parOut,
  input logic [7:0] parIn,
  input logic [1:0] serOut,
  input logic       wordTick
);
  logic       armed;
  logic [3:0] shareW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign shareW = (cfgRole == 2'd0) ? cfgWidth : (cfgWidth >> 1);

  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(wordTick) |-> $stable(parOut)) else $error("parOut moved off boundary"); // R2

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    wordTick && !cfgDdr |=> !wordTick || !$stable(cfgWidth) || !$stable(cfgRole)) else $error("back-to-back ticks"); // R3

  AST_SER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(wordTick) && !cfgDdr |-> serOut[0] == $past(parIn[0])) else $error("first serial bit wrong"); // R5

  AST_SLIP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    bitslip |=> $stable(parOut)) else $error("capture during slip"); // R7

  AST_PAR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(wordTick) && $stable(cfgWidth) && $stable(cfgRole) |-> (parOut >> shareW) == 8'd0) else $error("bits above share"); // R10
endmodule

bind lane_gearbox gearbox_checker uChk (.*);

// File: tb/tb_lane_gearbox.sv
module tb_lane_gearbox;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cfgWidth = 4'd8, cfgWidthHi = 4'd8;
  logic       cfgDdr = 1'b0, cfgDdrHi = 1'b0;
  logic [1:0] cfgRole = 2'd0, cfgRoleHi = 2'd0;
  logic       bitslip = 1'b0;
  logic [1:0] serInLo = 2'd0, serInHi = 2'd0;
  logic [7:0] parInLo = 8'd0, parInHi = 8'd0;
  logic [7:0] parOutLo, parOutHi;
  logic [1:0] serOutLo, serOutHi;
  logic       tickLo, tickHi;
  logic       dChain, sChain, dLoOut, sLoOut;

  lane_gearbox dut (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgDdr(cfgDdr), .cfgRole(cfgRole),
    .bitslip(bitslip), .serIn(serInLo), .deserCascIn(dChain), .deserCascOut(dLoOut),
    .parOut(parOutLo), .parIn(parInLo), .serOut(serOutLo), .serCascIn(sChain),
    .serCascOut(sLoOut), .wordTick(tickLo)
  );

  lane_gearbox dutHi (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidthHi), .cfgDdr(cfgDdrHi), .cfgRole(cfgRoleHi),
    .bitslip(bitslip), .serIn(serInHi), .deserCascIn(1'b0), .deserCascOut(dChain),
    .parOut(parOutHi), .parIn(parInHi), .serOut(serOutHi), .serCascIn(1'b0),
    .serCascOut(sChain), .wordTick(tickHi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  int  mcnt = 0;
  bit  needNew = 1'b1;

  typedef struct {
    int          due;
    bit          isSer;
    bit          casc;
    int          seg;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t scoreQ[$];
  bit   histQ[$];

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [15:0] lowMask(input int n);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = (i < n);
    return m;
  endfunction

  // monitor: compares every item that is due in this cycle
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = scoreQ.size() - 1; i >= 0; i--) begin
        if (scoreQ[i].due == cyc) begin
          exp_t        e;
          logic [15:0] act;
          e = scoreQ[i];
          if (e.isSer)     act = {14'd0, serOutLo};
          else if (e.casc) act = (16'(parOutHi) << e.seg) | 16'(parOutLo);
          else             act = 16'(parOutLo);
          chk(act === e.val, e.tag, act, e.val);
          scoreQ.delete(i);
        end
      end
    end
  end

  // driver: one cycle of stimulus plus expected results
  task automatic doCycle(input bit slip);
    int          seg, per, tot;
    bit          casc, tickExp;
    logic [15:0] word;
    if (needNew) begin
      parInLo = 8'($urandom);
      parInHi = 8'($urandom);
      needNew = 1'b0;
    end
    serInLo = 2'($urandom);
    serInHi = 2'($urandom);
    bitslip = slip;
    #1;
    casc = (cfgRole != 2'd0);
    seg  = casc ? int'(cfgWidth) / 2 : int'(cfgWidth);
    tot  = int'(cfgWidth);
    per  = cfgDdr ? tot / 2 : tot;
    if (casc) histQ.push_back(serInHi[0]);
    else if (cfgDdr) begin
      histQ.push_back(serInLo[0]);
      histQ.push_back(serInLo[1]);
    end else histQ.push_back(serInLo[0]);
    tickExp = (mcnt >= per - 1) && !slip;
    chk(tickLo === tickExp,
        slip ? "R7 boundary held by bitslip" : (cfgDdr ? "R4 tick spacing" : "R3 tick spacing"),
        {15'd0, tickLo}, {15'd0, tickExp});
    if (tickExp) begin
      word = '0;
      for (int i = 0; i < tot; i++) word[i] = histQ[histQ.size() - tot + i];
      scoreQ.push_back('{due: cyc + 1, isSer: 1'b0, casc: casc, seg: seg, val: word,
        tag: casc ? "R8 cascaded capture" : (cfgDdr ? "R4 double-rate capture" : "R2 R10 capture")});
      word = 16'(parInLo) & lowMask(seg);
      if (casc) word = word | ((16'(parInHi) & lowMask(seg)) << seg);
      for (int k = 0; k < per; k++) begin
        logic [15:0] v;
        if (cfgDdr) v = {14'd0, word[2*k+1], word[2*k]};
        else        v = {15'd0, word[k]};
        scoreQ.push_back('{due: cyc + 1 + k, isSer: 1'b1, casc: casc, seg: seg, val: v,
          tag: casc ? "R9 cascaded serial" : (cfgDdr ? "R6 double-rate serial" : "R5 serial order")});
      end
      needNew = 1'b1;
    end
    if (!slip) mcnt = tickExp ? 0 : mcnt + 1;
  endtask

  task automatic stepCycle(input bit slip);
    @(negedge clk);
    doCycle(slip);
  endtask

  task automatic applyReset(input logic [3:0] w, input bit ddr, input bit casc);
    @(negedge clk);
    rstN = 1'b0;
    bitslip = 1'b0;
    cfgWidth = w;  cfgDdr = ddr;   cfgRole = casc ? 2'd1 : 2'd0;
    cfgWidthHi = w; cfgDdrHi = ddr; cfgRoleHi = casc ? 2'd2 : 2'd0;
    scoreQ.delete();
    histQ.delete();
    for (int i = 0; i < 16; i++) histQ.push_back(1'b0);
    mcnt = 0;
    needNew = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(parOutLo === 8'd0, "R1 reset parallel", 16'(parOutLo), 16'd0);
    chk(serOutLo === 2'd0, "R1 reset serial", 16'(serOutLo), 16'd0);
    @(negedge clk);
    rstN = 1'b1;
    doCycle(1'b0);
  endtask

  task automatic runPhase(input logic [3:0] w, input bit ddr, input bit casc, input int n, input int slipAt);
    applyReset(w, ddr, casc);
    for (int i = 0; i < n; i++) stepCycle(i == slipAt);
    for (int i = 0; i < 16; i++) stepCycle(1'b0);
  endtask

  initial begin
    runPhase(4'd8,  1'b0, 1'b0, 60, 25);
    runPhase(4'd5,  1'b0, 1'b0, 40, 13);
    runPhase(4'd3,  1'b0, 1'b0, 30, -1);
    runPhase(4'd2,  1'b0, 1'b0, 30, 9);
    runPhase(4'd7,  1'b0, 1'b0, 40, -1);
    runPhase(4'd6,  1'b0, 1'b0, 30, -1);
    runPhase(4'd4,  1'b0, 1'b0, 30, 11);
    runPhase(4'd8,  1'b1, 1'b0, 40, 14);
    runPhase(4'd6,  1'b1, 1'b0, 30, -1);
    runPhase(4'd4,  1'b1, 1'b0, 30, 7);
    runPhase(4'd2,  1'b1, 1'b0, 20, 5);
    runPhase(4'd10, 1'b0, 1'b1, 60, 22);
    runPhase(4'd14, 1'b0, 1'b1, 60, 31);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", WATCHDOG_CYC, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule